// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block is a clocked model of the write side of a byte-wide parallel EEPROM. The host drives active-low chip enable, write enable and output enable, a 16-bit address and an 8-bit bidirectional data bus. Every pin is sampled on the system clock. Each write-enable pulse puts one byte into a temporary page buffer. The byte's position in the buffer comes from the low address bits. The page the buffer belongs to is taken from the address on the latest falling write-enable edge.

When write enable stays high for a programmable number of cycles, the load sequence is over and the block starts its internal program cycle. During that cycle `busy` is high. The program cycle first erases every buffered location and then writes the new bytes into storage. Bytes of the page that were not loaded keep their old values. When the block is not programming, a read with chip and output enable low returns the stored byte. At all other times the bus is released.

The storage holds `MEM_PAGES` pages. The page-address field is folded onto these pages by its low bits.

Top module: `eeprom_page_writer`

## Requirements
- R1: On a rising edge of `weN` with `ceN` low, the byte on `data` is buffered at offset `addr[6:0]`. Offsets can be loaded in any order, and a repeated offset keeps the last byte.
- R2: The target page is `addr[15:7]` as sampled at the last falling `weN` edge of the sequence. Storage uses page `addr[15:7] % MEM_PAGES`.
- R3: A sequence stays open as long as each new pulse begins within `LOAD_TIMEOUT` cycles of the previous rise, with no limit on the total length. `busy` rises exactly `LOAD_TIMEOUT` clock edges after the edge that samples the last rising `weN`.
- R4: `busy` stays high for exactly `PROG_CYCLES` cycles and then falls.
- R5: Only the offsets loaded in the sequence change. All other bytes of the page keep their contents.
- R6: Within the program cycle, every loaded cell is erased (set to all ones) before the new byte is written into it.
- R7: `weN` pulses while `busy` is high, and `weN` pulses while `ceN` is high, neither load data nor start a program cycle.
- R8: With `ceN` and `oeN` low, `weN` high and `busy` low, `data` carries the stored byte at `addr`. Otherwise the block leaves `data` undriven.
- R9: After reset, `busy` is low, the bus is undriven and the load mask is empty. The mask is empty again after every program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | 16 | Byte address: page in [15:7], offset in [6:0] |
| data | inout | 8 | Bidirectional data bus |
| busy | output | 1 | High while the program cycle runs |

## Verification
The assertions check, on every cycle, that the load mask and the latched page hold steady while programming and that a program cycle only starts with at least one loaded byte. They also check that the erase strobe comes before the commit strobe, that `busy` lasts more than one cycle, and that the mask is empty when `busy` falls. The bench scenarios are the only place that shows the stored data itself. They cover full-page sweeps over every page in descending offset order, a partial rewrite over odd offsets, duplicate loads, a page address that changes inside a sequence, page folding, a load window longer than the timeout, and pulses that are blocked by `busy` or by `ceN`. The bench also checks the exact edge on which `busy` rises and falls.

// File: rtl/eeprom_page_pkg.sv
package eeprom_page_pkg;
  typedef struct packed {
    logic latchPage;
    logic loadByte;
    logic eraseLoaded;
    logic commitLoaded;
  } pageStrobes_t;
endpackage

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
  import eeprom_page_pkg::*;
#(
  parameter int LOAD_TIMEOUT = 64,
  parameter int PROG_CYCLES  = 256
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ceN,
  input  logic         weN,
  output pageStrobes_t stb,
  output logic         busy
);
  localparam int TW = $clog2(LOAD_TIMEOUT + 1);
  localparam int PW = $clog2(PROG_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} ctrlState_t;

  ctrlState_t state;
  logic weQ;
  logic [TW-1:0] idleCnt;
  logic [PW-1:0] progCnt;
  logic weFall, weRise, accept;

  initial begin
    if (PROG_CYCLES < 2) $error("PROG_CYCLES must be at least 2");
    if (LOAD_TIMEOUT < 1) $error("LOAD_TIMEOUT must be at least 1");
  end

  always_comb begin
    weFall           = weQ & ~weN;
    weRise           = ~weQ & weN;
    accept           = ~ceN & (state != ST_PROG);
    stb.latchPage    = weFall & accept;
    stb.loadByte     = weRise & accept;
    stb.eraseLoaded  = (state == ST_PROG) && (progCnt == '0);
    stb.commitLoaded = (state == ST_PROG) && (progCnt == PW'(PROG_CYCLES - 1));
    busy             = (state == ST_PROG);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      weQ     <= 1'b1;
      idleCnt <= '0;
      progCnt <= '0;
    end else begin
      weQ <= weN;
      unique case (state)
        ST_IDLE: begin
          if (stb.loadByte) begin
            state   <= ST_LOAD;
            idleCnt <= '0;
          end
        end
        ST_LOAD: begin
          if (stb.loadByte || !weN) begin
            idleCnt <= '0;
          end else if (idleCnt == TW'(LOAD_TIMEOUT - 1)) begin
            state   <= ST_PROG;
            progCnt <= '0;
          end else begin
            idleCnt <= idleCnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (stb.commitLoaded) state <= ST_IDLE;
          progCnt <= progCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_page_data.sv
module eeprom_page_data
  import eeprom_page_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int OFFS_W    = 7,
  parameter int MEM_PAGES = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pageStrobes_t           stb,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      dataIn,
  output logic [DATA_W-1:0]      dataOut,
  output logic [(1<<OFFS_W)-1:0] validMask,
  output logic [$clog2(MEM_PAGES)-1:0] pageQ
);
  localparam int PAGE_BYTES = 1 << OFFS_W;
  localparam int SEL_W      = $clog2(MEM_PAGES);
  localparam int MEM_AW     = SEL_W + OFFS_W;

  logic [DATA_W-1:0] pageBuf [PAGE_BYTES];
  logic [DATA_W-1:0] storage [MEM_PAGES*PAGE_BYTES];
  logic [OFFS_W-1:0] offs;
  logic [SEL_W-1:0]  pageIn;

  assign offs   = addr[OFFS_W-1:0];
  assign pageIn = addr[OFFS_W +: SEL_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMask <= '0;
      pageQ     <= '0;
    end else begin
      if (stb.latchPage) pageQ <= pageIn;
      if (stb.commitLoaded) validMask <= '0;
      else if (stb.loadByte) validMask[offs] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.loadByte) pageBuf[offs] <= dataIn;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (validMask[i]) begin
        if (stb.eraseLoaded)
          storage[MEM_AW'({pageQ, OFFS_W'(i)})] <= '1;
        else if (stb.commitLoaded)
          storage[MEM_AW'({pageQ, OFFS_W'(i)})] <= pageBuf[i];
      end
    end
  end

  assign dataOut = storage[{pageIn, offs}];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eeprom_page_pkg::*;
#(
  parameter int LOAD_TIMEOUT = 64,
  parameter int PROG_CYCLES  = 256,
  parameter int MEM_PAGES    = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        weN,
  input  logic        oeN,
  input  logic [15:0] addr,
  inout  wire  [7:0]  data,
  output logic        busy
);
  localparam int OFFS_W     = 7;
  localparam int PAGE_BYTES = 1 << OFFS_W;
  localparam int SEL_W      = $clog2(MEM_PAGES);

  pageStrobes_t          stb;
  logic [7:0]            dataOut;
  logic [PAGE_BYTES-1:0] validMask;
  logic [SEL_W-1:0]      pageQ;
  logic                  driveEn;

  eeprom_page_ctrl #(
    .LOAD_TIMEOUT(LOAD_TIMEOUT),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .ceN (ceN),
    .weN (weN),
    .stb (stb),
    .busy(busy)
  );

  eeprom_page_data #(
    .ADDR_W   (16),
    .DATA_W   (8),
    .OFFS_W   (OFFS_W),
    .MEM_PAGES(MEM_PAGES)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .addr     (addr),
    .dataIn   (data),
    .dataOut  (dataOut),
    .validMask(validMask),
    .pageQ    (pageQ)
  );

  assign driveEn = ~ceN & ~oeN & weN & ~busy;
  assign data    = driveEn ? dataOut : 8'bz;
endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk
  import eeprom_page_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int SEL_W      = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busy,
  input logic [PAGE_BYTES-1:0] validMask,
  input logic [SEL_W-1:0]      pageQ,
  input pageStrobes_t          stb
);
  logic erased;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) erased <= 1'b0;
    else if (stb.eraseLoaded) erased <= 1'b1;
    else if (stb.commitLoaded) erased <= 1'b0;
  end

  a_r3_prog_needs_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (validMask != '0));

  a_r4_busy_min_two: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);

  a_r5_mask_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(validMask));

  a_r2_page_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(pageQ));

  a_r6_erase_first: assert property (@(posedge clk) disable iff (!rstN)
    stb.commitLoaded |-> erased);

  a_r9_mask_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (validMask == '0));
endmodule

bind eeprom_page_writer eeprom_page_writer_chk #(
  .PAGE_BYTES(PAGE_BYTES),
  .SEL_W     (SEL_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .validMask(validMask),
  .pageQ    (pageQ),
  .stb      (stb)
);

// File: tb/eeprom_page_writer_test.sv
module eeprom_page_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int T     = 8;
  localparam int P     = 6;
  localparam int PAGES = 4;

  logic clk = 0, rstN = 0, ceN = 1, weN = 1, oeN = 1;
  logic [15:0] addr = '0;
  logic [7:0] tbData = '0;
  logic tbDrive = 0;
  wire  [7:0] dataBus;
  logic busy;
  int checks = 0, fails = 0;

  logic [7:0] model [PAGES*128];
  logic [7:0] stage [128];
  bit         stageV [128];
  int         stagePage;

  assign dataBus = tbDrive ? tbData : 8'bz;
  for (genvar g = 0; g < 8; g++) begin : g_pu
    pullup (dataBus[g]);
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_page_writer #(.LOAD_TIMEOUT(T), .PROG_CYCLES(P), .MEM_PAGES(PAGES)) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .data(dataBus), .busy(busy));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic loadByte(input int page, input int off, input logic [7:0] d, input bit record);
    @(negedge clk);
    addr = {page[8:0], off[6:0]}; tbData = d; tbDrive = 1; ceN = 0; weN = 0;
    @(negedge clk);
    weN = 1;
    @(negedge clk);
    ceN = 1; tbDrive = 0;
    if (record) begin
      stage[off] = d; stageV[off] = 1; stagePage = page % PAGES;
    end
  endtask

  task automatic commitStage();
    for (int i = 0; i < 128; i++) begin
      if (stageV[i]) model[stagePage*128 + i] = stage[i];
      stageV[i] = 0;
    end
  endtask

  // R3 R4: busy rises T edges after the last rise and stays up P cycles
  task automatic finishPage();
    for (int j = 1; j <= T + P; j++) begin
      @(negedge clk);
      check((j < T) ? "R3 busy timing" : "R4 busy length", busy, (j >= T && j < T + P));
    end
    commitStage();
  endtask

  task automatic readByte(input int page, input int off, output logic [7:0] v);
    @(negedge clk);
    addr = {page[8:0], off[6:0]}; ceN = 0; oeN = 0;
    #1 v = dataBus;
    ceN = 1; oeN = 1;
  endtask

  task automatic checkPage(input int page, input string req);
    logic [7:0] v;
    for (int i = 0; i < 128; i++) begin
      readByte(page, i, v);
      check(req, v, model[page*128 + i]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 128; i++) stageV[i] = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 busy after reset", busy, 0);
    #1 check("R9 bus released", dataBus, 8'hFF);
    rstN = 1;
    @(negedge clk);

    // R1 R8: full pages, descending offset order, every page
    for (int pg = 0; pg < PAGES; pg++) begin
      for (int off = 127; off >= 0; off--)
        loadByte(pg, off, 8'((pg*37 + off*5 + 1) & 8'h7F), 1);
      finishPage();
    end
    for (int pg = 0; pg < PAGES; pg++) checkPage(pg, "R1 R8 full page");

    // R5 R6: partial rewrite over odd offsets of page 1
    for (int off = 1; off < 128; off += 2) loadByte(1, off, 8'(off ^ 8'h55), 1);
    finishPage();
    checkPage(1, "R5 R6 partial page");
    checkPage(0, "R5 other page untouched");

    // R1: duplicate offset keeps last byte
    loadByte(2, 10, 8'h11, 1);
    loadByte(2, 10, 8'h22, 1);
    finishPage();
    readByte(2, 10, v);
    check("R1 duplicate offset", v, 8'h22);

    // R2: page from last falling edge; folded page
    loadByte(3, 20, 8'h31, 0);
    loadByte(3, 21, 8'h32, 0);
    loadByte(0, 22, 8'h33, 1);
    stage[20] = 8'h31; stageV[20] = 1; stage[21] = 8'h32; stageV[21] = 1;
    finishPage();
    checkPage(0, "R2 last page latch");
    checkPage(3, "R2 old page untouched");
    loadByte(5, 3, 8'h44, 1);
    finishPage();
    readByte(1, 3, v);
    check("R2 page folding", v, 8'h44);

    // R3: window longer than the timeout stays open
    for (int i = 0; i < 200; i++) begin
      loadByte(2, i % 128, 8'((i * 3) & 8'h7F), 1);
      check("R3 long window no busy", busy, 0);
    end
    finishPage();
    checkPage(2, "R3 long window data");

    // R7 R8: pulses during busy are ignored, bus released while busy
    loadByte(0, 0, 8'h5A, 1);
    for (int j = 1; j <= T; j++) @(negedge clk);
    check("R4 busy high", busy, 1);
    readByte(0, 0, v);
    check("R8 bus released while busy", v, 8'hFF);
    loadByte(0, 1, 8'h00, 0);
    while (busy) @(negedge clk);
    commitStage();
    repeat (T + 3) @(negedge clk);
    check("R7 no restart after busy", busy, 0);
    readByte(0, 1, v);
    check("R7 busy pulse ignored", v, model[1]);
    readByte(0, 0, v);
    check("R7 byte before busy kept", v, 8'h5A);

    // R7: pulse with ceN high is ignored
    @(negedge clk);
    addr = {9'd0, 7'd5}; tbData = 8'h66; tbDrive = 1; ceN = 1; weN = 0;
    @(negedge clk); weN = 1;
    @(negedge clk); tbDrive = 0;
    repeat (T + 3) @(negedge clk);
    check("R7 ceN high no busy", busy, 0);
    readByte(0, 5, v);
    check("R7 ceN high no load", v, model[5]);

    // R8: oeN high leaves bus released
    @(negedge clk);
    addr = '0; ceN = 0; oeN = 1;
    #1 check("R8 oeN high released", dataBus, 8'hFF);
    ceN = 1;

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule